// File: doc/BRIEF.md
# Chainable Debounced Input Serializer

This block models one device of a chain of input serializers. It watches eight digital field inputs and filters each one through a debounce stage. The filter time is picked by a two-pin selector and counted in ticks of a divided timebase. When the chip-select line falls, the debounced byte is frozen into a shift register. If the frame-length pin asks for it, a status byte is frozen alongside the data. The status byte carries a 5-bit CRC of the data and the alarm conditions.

The host clocks bits out on `sdo`, most significant first. Each device passes the bits from its upstream neighbour (`sdi`) along behind its own frame. A chain of these devices therefore shows the host the nearest device's frame first, and each frame arrives unbroken. A registered fault output follows the overtemperature and undervoltage alarm inputs. The serial pins are sampled by the block clock, so `sclk` must run well below it.

Top module: `dchain_in_serializer`

## Requirements
- R1: While `rst_n` is low and after it rises with idle inputs, `sdo` and `fault` are 0 and the debounced byte is 0.
- R2: A capture happens when `cs_n` is seen high on one clock and low on the next. From the following clock, `sdo` shows bit 7 of the debounced byte.
- R3: If `frame_short` is 1 at capture, the frame is the 8 data bits, MSB first, one bit per rising `sclk` edge seen while `cs_n` is low. Bits then received on `sdi` follow in arrival order, 8 positions later.
- R4: If `frame_short` is 0 at capture, the frame is the data byte and then the status byte (16 bits). `sdi` bits follow 16 positions later.
- R5: The status byte holds the CRC in bits 7:3 and the inverted undervoltage alarm in bit 2. Bit 1 is the overtemperature alarm and bit 0 is the inverted undervoltage warning, all sampled at capture.
- R6: The CRC is data·x^5 mod (x^5+x^4+x^2+1): zero initial value, data taken MSB first, data byte only.
- R7: With `db_sel` = 00, the debounced byte takes the raw byte on the next clock.
- R8: `db_sel[1]` is the first selector pin. For 01, 10 and 11, an input changes only after it has differed from its debounced value for `CNT_SHORT`, `CNT_MED` or `CNT_LONG` consecutive ticks. A tick comes every `TICK_DIV` clocks. Shorter excursions leave it unchanged.
- R9: `fault` is 1 on the clock after `alarm_ot` or `alarm_uv` is 1. `warn_uv` has no effect on it.
- R10: While `cs_n` is high, `sclk` edges do not move the shift register and `sdo` holds.
- R11: The frame length is latched at capture; changing `frame_short` mid-frame does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_raw | input | 8 | Raw field inputs (already synchronous) |
| db_sel | input | 2 | Debounce selector, bit 1 is the first pin |
| frame_short | input | 1 | 1: data-only frame, 0: data plus status |
| alarm_ot | input | 1 | Overtemperature alarm, active high |
| alarm_uv | input | 1 | Undervoltage alarm, active high |
| warn_uv | input | 1 | Undervoltage warning, active high |
| cs_n | input | 1 | Chip select, active low, falling edge captures |
| sclk | input | 1 | Serial clock, rising edge shifts |
| sdi | input | 1 | Serial input from the upstream device |
| sdo | output | 1 | Serial output toward the host |
| fault | output | 1 | Registered alarm summary |

## Verification
Two functions can meet on one clock: a debounce counter ending its window and the chip-select capture. Capture only ever sees the byte as it stood before that edge. The bench places captures a few cycles after an input step, and again after the whole window has elapsed. It expects the old byte in the first case and the new byte in the second; a glitch one tick short of the window must never appear. Shifting and chaining meet the same way, since both chained devices move on one `sclk` edge. The far device's bits must appear exactly one frame behind the near device's.

// File: rtl/dchain_ser_pkg.sv
package dchain_ser_pkg;

   localparam int unsigned IN_W    = 8;
   localparam int unsigned STAT_W  = 8;
   localparam int unsigned CRC_W   = 5;
   localparam int unsigned FRAME_W = IN_W + STAT_W;
   // x^5 + x^4 + x^2 + 1 without the leading term
   localparam logic [CRC_W-1:0] CRC_POLY = 5'b10101;

   typedef enum logic [1:0] {
      DB_NONE  = 2'b00,
      DB_SHORT = 2'b01,
      DB_MED   = 2'b10,
      DB_LONG  = 2'b11
   } db_mode_e;

   typedef struct packed {
      logic [CRC_W-1:0] crc;
      logic             uv_ok;
      logic             ot;
      logic             uvw_ok;
   } stat_byte_t;

   function automatic logic [CRC_W-1:0] crc_of(input logic [IN_W-1:0] d);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = '0;
      for (int i = IN_W - 1; i >= 0; i--) begin
         fb = c[CRC_W-1] ^ d[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/dchain_ser_timebase.sv
module dchain_ser_timebase #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW   = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/dchain_ser_debounce.sv
module dchain_ser_debounce
   import dchain_ser_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned CNT_SHORT = 25,
   parameter int unsigned CNT_MED   = 750,
   parameter int unsigned CNT_LONG  = 3000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  db_mode_e         sel,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] state
);
   localparam int unsigned CMAX = (CNT_LONG > CNT_MED)
                                  ? ((CNT_LONG > CNT_SHORT) ? CNT_LONG : CNT_SHORT)
                                  : ((CNT_MED > CNT_SHORT) ? CNT_MED : CNT_SHORT);
   localparam int unsigned CW   = $clog2(CMAX + 1);

   logic [CW-1:0] last_idx;
   logic          bypass;

   always_comb begin
      bypass   = 1'b0;
      last_idx = '0;
      unique case (sel)
         DB_NONE:  bypass   = 1'b1;
         DB_SHORT: last_idx = CW'(CNT_SHORT - 1);
         DB_MED:   last_idx = CW'(CNT_MED - 1);
         DB_LONG:  last_idx = CW'(CNT_LONG - 1);
         default:  bypass   = 1'b1;
      endcase
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [CW-1:0] cnt;
      logic          st;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
            st  <= 1'b0;
         end else if (bypass) begin
            cnt <= '0;
            st  <= raw[b];
         end else if (raw[b] == st) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt >= last_idx) begin
               cnt <= '0;
               st  <= raw[b];
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

      assign state[b] = st;
   end
endmodule

// File: rtl/dchain_ser_shifter.sv
module dchain_ser_shifter #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdi,
   input  logic               short_req,
   input  logic [FRAME_W-1:0] load_word,
   output logic               sdo,
   output logic               mode_lat,
   output logic               shift_pulse,
   output logic               sr_lsb
);
   logic               cs_q;
   logic               sclk_q;
   logic               capture;
   logic [FRAME_W-1:0] sr;

   assign capture     = cs_q & ~cs_n;
   assign shift_pulse = ~cs_n & sclk & ~sclk_q & ~capture;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr       <= '0;
         mode_lat <= 1'b0;
      end else if (capture) begin
         sr       <= load_word;
         mode_lat <= short_req;
      end else if (shift_pulse) begin
         sr       <= {sr[FRAME_W-2:0], sdi};
      end
   end

   assign sdo    = mode_lat ? sr[DATA_W-1] : sr[FRAME_W-1];
   assign sr_lsb = sr[0];
endmodule

// File: rtl/dchain_in_serializer.sv
module dchain_in_serializer
   import dchain_ser_pkg::*;
#(
   parameter int unsigned TICK_DIV  = 1000,
   parameter int unsigned CNT_SHORT = 25,
   parameter int unsigned CNT_MED   = 750,
   parameter int unsigned CNT_LONG  = 3000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_raw,
   input  logic [1:0] db_sel,
   input  logic       frame_short,
   input  logic       alarm_ot,
   input  logic       alarm_uv,
   input  logic       warn_uv,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   output logic       sdo,
   output logic       fault
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (CNT_SHORT < 1 || CNT_MED < CNT_SHORT || CNT_LONG < CNT_MED) begin : g_bad_cnt
      $error("debounce counts must satisfy 1 <= SHORT <= MED <= LONG");
   end

   logic               tick;
   logic [IN_W-1:0]    db_state;
   stat_byte_t         stat;
   logic [FRAME_W-1:0] load_word;
   logic               mode_lat;
   logic               shift_pulse;
   logic               sr_lsb;

   dchain_ser_timebase #(.DIV(TICK_DIV)) u_tb (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   dchain_ser_debounce #(
      .WIDTH    (IN_W),
      .CNT_SHORT(CNT_SHORT),
      .CNT_MED  (CNT_MED),
      .CNT_LONG (CNT_LONG)
   ) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .sel  (db_mode_e'(db_sel)),
      .raw  (in_raw),
      .state(db_state)
   );

   always_comb begin
      stat.crc    = crc_of(db_state);
      stat.uv_ok  = ~alarm_uv;
      stat.ot     = alarm_ot;
      stat.uvw_ok = ~warn_uv;
      load_word   = frame_short ? {{STAT_W{1'b0}}, db_state} : {db_state, stat};
   end

   dchain_ser_shifter #(.DATA_W(IN_W), .FRAME_W(FRAME_W)) u_sh (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .sdi        (sdi),
      .short_req  (frame_short),
      .load_word  (load_word),
      .sdo        (sdo),
      .mode_lat   (mode_lat),
      .shift_pulse(shift_pulse),
      .sr_lsb     (sr_lsb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault <= 1'b0;
      else        fault <= alarm_ot | alarm_uv;
   end
endmodule

// File: rtl/dchain_in_serializer_chk.sv
module dchain_in_serializer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sdi,
   input logic       sdo,
   input logic [1:0] db_sel,
   input logic [7:0] in_raw,
   input logic [7:0] db_state,
   input logic       tick,
   input logic       mode_lat,
   input logic       shift_pulse,
   input logic       sr_lsb
);
   AST_CAPTURE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> sdo == $past(db_state[7])); // R2
   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> sr_lsb == $past(sdi)); // R3
   AST_DB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (db_sel == 2'b00) |=> db_state == $past(in_raw)); // R7
   AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (db_sel != 2'b00 && !tick) |=> $stable(db_state)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> $stable(sdo)); // R10
   AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cs_n) && $past(!cs_n, 2)) |-> $stable(mode_lat)); // R11
endmodule

bind dchain_in_serializer dchain_in_serializer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sdi        (sdi),
   .sdo        (sdo),
   .db_sel     (db_sel),
   .in_raw     (in_raw),
   .db_state   (db_state),
   .tick       (tick),
   .mode_lat   (mode_lat),
   .shift_pulse(shift_pulse),
   .sr_lsb     (sr_lsb)
);

// File: tb/dchain_in_serializer_tb.sv
module dchain_in_serializer_tb;
   localparam int D  = 4;
   localparam int LS = 2;
   localparam int LM = 6;
   localparam int LL = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] din_a = '0, din_b = '0;
   logic [1:0] dbs_a = '0, dbs_b = '0;
   logic mode_s = 1'b0;
   logic ot_a = 0, uv_a = 0, wn_a = 0, ot_b = 0, uv_b = 0, wn_b = 0;
   logic cs_n = 1'b1, sclk = 1'b0;
   logic far_sdi = 1'b1;
   logic link, sdo, fault_a, fault_b;
   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc++;

   dchain_in_serializer #(.TICK_DIV(D), .CNT_SHORT(LS), .CNT_MED(LM), .CNT_LONG(LL)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_raw(din_a), .db_sel(dbs_a), .frame_short(mode_s),
      .alarm_ot(ot_a), .alarm_uv(uv_a), .warn_uv(wn_a), .cs_n(cs_n), .sclk(sclk),
      .sdi(link), .sdo(sdo), .fault(fault_a));

   dchain_in_serializer #(.TICK_DIV(D), .CNT_SHORT(LS), .CNT_MED(LM), .CNT_LONG(LL)) u_far (
      .clk(clk), .rst_n(rst_n), .in_raw(din_b), .db_sel(dbs_b), .frame_short(mode_s),
      .alarm_ot(ot_b), .alarm_uv(uv_b), .warn_uv(wn_b), .cs_n(cs_n), .sclk(sclk),
      .sdi(far_sdi), .sdo(link), .fault(fault_b));

   function automatic logic [4:0] ref_crc(input logic [7:0] d);
      logic [12:0] r;
      r = {d, 5'b0};
      for (int i = 12; i >= 5; i--)
         if (r[i]) r = r ^ (13'b110101 << (i - 5));
      return r[4:0];
   endfunction

   function automatic logic [7:0] ref_stat(input logic [7:0] d, input logic ot, uv, wn);
      return {ref_crc(d), ~uv, ot, ~wn};
   endfunction

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input int nbits, input int flip_at, output logic [47:0] bits);
      bits = '0;
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         if (i == flip_at) mode_s = ~mode_s;
         bits = {bits[46:0], sdo};
         sclk = 1'b1;
         @(negedge clk) sclk = 1'b0;
         @(negedge clk);
      end
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int lim_of(input int lvl);
      return (lvl == 1) ? LS : (lvl == 2) ? LM : LL;
   endfunction

   initial begin
      logic [47:0] got;
      int t0;
      repeat (3) @(negedge clk);
      check("R1 sdo in reset", {47'b0, sdo}, 48'b0);
      check("R1 fault in reset", {47'b0, fault_a}, 48'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 sdo after reset", {47'b0, sdo}, 48'b0);
      mode_s = 1'b1;
      do_read(20, -1, got);
      check("R1 debounced byte zero after reset", got, {8'h00, 8'h00, 4'hF});

      // R3 R4 R5 R6 sweep over every data value, two chained devices
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         din_a = 8'(v); din_b = 8'(v) ^ 8'h3C;
         {wn_a, uv_a, ot_a} = 3'(v);
         {wn_b, uv_b, ot_b} = 3'(v >> 3);
         @(negedge clk);
         mode_s = 1'b1;
         do_read(20, -1, got);
         check("R3 short frame chain", got, {din_a, din_b, 4'hF});
         mode_s = 1'b0;
         do_read(36, -1, got);
         check("R4/R5/R6 long frame chain", got,
               {din_a, ref_stat(din_a, ot_a, uv_a, wn_a),
                din_b, ref_stat(din_b, ot_b, uv_b, wn_b), 4'hF});
      end
      {wn_a, uv_a, ot_a, wn_b, uv_b, ot_b} = '0;
      din_b = 8'h00;

      // R9 fault follows alarms, warning ignored
      for (int k = 0; k < 8; k++) begin
         @(negedge clk) {wn_a, uv_a, ot_a} = 3'(k);
         @(negedge clk);
         @(negedge clk);
         check("R9 fault", {47'b0, fault_a}, {47'b0, ot_a | uv_a});
      end
      {wn_a, uv_a, ot_a} = '0;

      // R2 and R10: partial read, idle clocks with chip select high
      din_a = 8'hA5; mode_s = 1'b0;
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R2 first bit after capture", {47'b0, sdo}, 48'd1);
      sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
      @(negedge clk);
      check("R3 second bit", {47'b0, sdo}, 48'd0);
      cs_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         sclk = 1'b1;
         @(negedge clk) sclk = 1'b0;
         @(negedge clk);
      end
      check("R10 sdo held while deselected", {47'b0, sdo}, 48'd0);

      // R11 frame length latched at capture
      mode_s = 1'b0;
      do_read(36, 5, got);
      check("R11 long frame despite mid-frame change", got,
            {8'hA5, ref_stat(8'hA5, 1'b0, 1'b0, 1'b0), 8'h00, ref_stat(8'h00, 1'b0, 1'b0, 1'b0), 4'hF});
      mode_s = 1'b1;
      do_read(20, 7, got);
      check("R11 short frame despite mid-frame change", got, {8'hA5, 8'h00, 4'hF});

      // R7 R8 debounce levels
      mode_s = 1'b1;
      for (int lvl = 0; lvl < 4; lvl++) begin
         @(negedge clk) dbs_a = 2'(lvl); din_a = 8'h00;
         repeat (2 * LL * D + 10) @(negedge clk);
         din_a = 8'hA5; t0 = cyc;
         do_read(20, -1, got);
         if (lvl == 0) check("R7 bypass takes new byte", got, {8'hA5, 8'h00, 4'hF});
         else          check("R8 early capture keeps old byte", got, {8'h00, 8'h00, 4'hF});
         if (lvl != 0) begin
            while (cyc < t0 + lim_of(lvl) * D + 3) @(negedge clk);
            do_read(20, -1, got);
            check("R8 byte settles after window", got, {8'hA5, 8'h00, 4'hF});
            @(negedge clk) din_a = 8'h5A;
            repeat ((lim_of(lvl) - 1) * D - 1) @(negedge clk);
            din_a = 8'hA5;
            repeat (lim_of(lvl) * D + 4) @(negedge clk);
            do_read(20, -1, got);
            check("R8 short glitch rejected", got, {8'hA5, 8'h00, 4'hF});
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish (all requirements)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule